// File: doc/BRIEF.md
# Serial Line Transmitter with Break Blocks

This block turns bytes into an asynchronous serial stream on a line that rests high. A write puts a word into a single holding register. At the next bit strobe the word moves into a shift register, and the block sends a frame: a low start bit, then 8 or 9 data bits least significant first, then a high stop bit. An empty flag tells the writer when the holding register can take the next word. If the holding register is full when a stop bit ends, the next frame follows straight after it with no gap. The bit rate comes from an external strobe that pulses once per bit period. The block has no baud generator, no parity and no interrupts.

A send-break request replaces data with blocks of zeros. Each block is exactly one frame long, all low. A short pulse on the request gives one block. Holding the request high gives whole blocks back to back, and a block is never cut short. After the last block the line goes high for at least one bit before anything else starts. Clearing the enable never cuts a frame short: the frame or block already on the line finishes, and then the line rests high.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, tx_o is 1 and empty_o is 1.
- R2: A data frame is a start bit of 0, then the data bits with bit 0 first, then a stop bit of 1. There are 8 bits (wr_data_i[7:0]) when nine_bit_i is 0 and 9 bits (wr_data_i[8:0]) when it is 1. Each bit lasts one bit_tick_i period, and tx_o changes only on a clock edge where bit_tick_i is high.
- R3: A write (wr_i high) stores wr_data_i and clears empty_o on that edge. empty_o sets on the tick edge where the held word moves into the shifter, unless a write happens on that same edge.
- R4: If a word is held when a stop bit ends, its start bit follows on the very next bit period.
- R5: A break block is all zeros and lasts 10 bit periods when nine_bit_i is 0, or 11 when it is 1.
- R6: A send_brk_i pulse that falls before the block it starts has ended gives exactly one block. After that block the line returns to idle or to data.
- R7: While send_brk_i stays high, whole blocks follow one another with no gap. A block already started always runs to its full length after send_brk_i falls.
- R8: After the last break block, tx_o is 1 for at least one bit period before the next start bit.
- R9: A break request made during a data frame begins right after that frame's stop bit. At a frame boundary a pending break wins over a held word, and that word is sent after the break and one high bit.
- R10: With tx_en_i low, a frame or block already in progress completes, then tx_o stays 1. No new frame or block starts, and a held word stays held (empty_o stays 0).
- R11: nine_bit_i is sampled when a frame or block starts. Changing it mid-frame does not change the current frame's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle strobe, once per bit period |
| tx_en_i | input | 1 | Transmitter enable |
| nine_bit_i | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| send_brk_i | input | 1 | Break request |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 9 | Word to send |
| tx_o | output | 1 | Serial line, idle high |
| empty_o | output | 1 | Holding register is free |

## Verification
A wrong bit counter or latched frame length shows up as a stop bit, or the end of a break, that comes one bit period early or late. That error is visible at tx_o by the end of the first affected frame. A broken break-request latch shows as a zero run that is missing, doubled or truncated, and this is visible within one block length of the request. A wrong empty flag is visible at empty_o on the edge right after a write or a load. The bench compares both outputs every cycle against an independent model, and it also decodes the logged line for the frame, block and gap lengths.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_DATA = 2'd1,
    TX_BRK  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      empty_o <= 1'b1;
    end else begin
      if (wr_i) data_o <= wr_data_i;
      // a write on the load edge keeps the register full
      if (wr_i)        empty_o <= 1'b0;
      else if (take_i) empty_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              step_i,
  output logic              bit_o
);
  localparam int SH_W = DATA_W + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] ld_vec;

  // stop bit sits above the last data bit; narrow mode pads the top data slot with 1
  for (genvar i = 0; i < SH_W; i++) begin : g_ld
    if (i == SH_W - 1) begin : g_stop
      assign ld_vec[i] = 1'b1;
    end else if (i == DATA_W - 1) begin : g_top
      assign ld_vec[i] = wide_i ? load_data_i[i] : 1'b1;
    end else begin : g_dat
      assign ld_vec[i] = load_data_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '1;
    else if (load_i)  sh_q <= ld_vec;
    else if (step_i)  sh_q <= {1'b1, sh_q[SH_W-1:1]};
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/uart_tx_bitcnt.sv
module uart_tx_bitcnt #(
  parameter int FRAME_MAX = 11,
  parameter int CNT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             wide_i,
  output logic [CNT_W-1:0] idx_o,
  output logic [CNT_W-1:0] last_o,
  output logic             at_end_o
);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(FRAME_MAX - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(FRAME_MAX - 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o  <= '0;
      last_o <= LAST_NARROW;
    end else if (clr_i) begin
      idx_o  <= '0;
      last_o <= wide_i ? LAST_WIDE : LAST_NARROW;
    end else if (inc_i) begin
      idx_o  <= idx_o + 1'b1;
    end
  end

  assign at_end_o = (idx_o == last_o);
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              tx_en_i,
  input  logic              nine_bit_i,
  input  logic              send_brk_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              tx_o,
  output logic              empty_o
);
  localparam int FRAME_MAX = DATA_W + 2;
  localparam int CNT_W     = $clog2(FRAME_MAX);

  tx_state_e         state_q, state_d;
  logic              tx_d;
  logic              brk_pend_q;
  logic [DATA_W-1:0] hold_data;
  logic              sh_bit;
  logic [CNT_W-1:0]  idx_q, last_q;
  logic              at_end;
  logic              go_brk, go_data, decide, start_brk, load, step, cnt_inc;

  assign go_brk  = tx_en_i & (brk_pend_q | send_brk_i);
  assign go_data = tx_en_i & ~empty_o & ~go_brk;

  always_comb begin
    state_d   = state_q;
    tx_d      = tx_o;
    decide    = 1'b0;
    start_brk = 1'b0;
    load      = 1'b0;
    step      = 1'b0;
    cnt_inc   = 1'b0;
    if (bit_tick_i) begin
      unique case (state_q)
        TX_IDLE: decide = 1'b1;
        TX_DATA: begin
          if (at_end) decide = 1'b1;
          else begin
            step    = 1'b1;
            cnt_inc = 1'b1;
            tx_d    = sh_bit;
          end
        end
        TX_BRK: begin
          if (!at_end)     cnt_inc   = 1'b1;
          else if (go_brk) start_brk = 1'b1;
          else begin
            // guaranteed mark bit after the final block
            state_d = TX_IDLE;
            tx_d    = 1'b1;
          end
        end
        default: state_d = TX_IDLE;
      endcase
      if (decide) begin
        if (go_brk)       start_brk = 1'b1;
        else if (go_data) load      = 1'b1;
        else begin
          state_d = TX_IDLE;
          tx_d    = 1'b1;
        end
      end
      if (start_brk) begin
        state_d = TX_BRK;
        tx_d    = 1'b0;
      end
      if (load) begin
        state_d = TX_DATA;
        tx_d    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= TX_IDLE;
      tx_o       <= 1'b1;
      brk_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      tx_o    <= tx_d;
      // requests are latched outside a block; inside a block the level decides
      if (start_brk || state_q == TX_BRK) brk_pend_q <= 1'b0;
      else if (send_brk_i)               brk_pend_q <= 1'b1;
    end
  end

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .wr_data_i(wr_data_i),
    .take_i   (load),
    .data_o   (hold_data),
    .empty_o  (empty_o)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .wide_i     (nine_bit_i),
    .load_data_i(hold_data),
    .step_i     (step),
    .bit_o      (sh_bit)
  );

  uart_tx_bitcnt #(.FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_brk | load),
    .inc_i   (cnt_inc),
    .wide_i  (nine_bit_i),
    .idx_o   (idx_q),
    .last_o  (last_q),
    .at_end_o(at_end)
  );
endmodule

// File: rtl/uart_tx_brk_chk.sv
module uart_tx_brk_chk
  import uart_tx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_tick_i,
  input logic             tx_en_i,
  input logic             wr_i,
  input logic             tx_o,
  input logic             empty_o,
  input tx_state_e        state_q,
  input logic [CNT_W-1:0] idx_q,
  input logic [CNT_W-1:0] last_q
);
  a_r2_line_holds_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(tx_o));

  a_r2_index_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= last_q);

  a_r3_write_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !empty_o);

  a_r5_break_line_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_BRK) |-> !tx_o);

  a_r10_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_IDLE) |-> tx_o);

  a_r10_no_start_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && state_q == TX_IDLE) |=> (state_q == TX_IDLE));
endmodule

bind uart_tx_brk uart_tx_brk_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_tick_i(bit_tick_i),
  .tx_en_i   (tx_en_i),
  .wr_i      (wr_i),
  .tx_o      (tx_o),
  .empty_o   (empty_o),
  .state_q   (state_q),
  .idx_q     (idx_q),
  .last_q    (last_q)
);

// File: tb/uart_tx_brk_tb.sv
module uart_tx_brk_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       b_tick = 1'b0, b_en = 1'b0, b_nine = 1'b0, b_brk = 1'b0, b_wr = 1'b0;
  logic [8:0] b_wd = '0;
  logic       tx, empty;

  int checks = 0, errors = 0, tcnt = 0;
  logic bitlog [0:4095];
  int nlog = 0;

  // reference model
  int m_st = 0, m_idx = 0, m_last = 9;
  logic [9:0] m_sh = '1;
  logic [8:0] m_hold = '0;
  logic m_tx = 1, m_empty = 1, m_pend = 0;

  always #2 clk = ~clk;

  uart_tx_brk u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(b_tick), .tx_en_i(b_en),
    .nine_bit_i(b_nine), .send_brk_i(b_brk), .wr_i(b_wr), .wr_data_i(b_wd),
    .tx_o(tx), .empty_o(empty)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    int n_st, n_idx, n_last;
    logic [9:0] n_sh;
    logic n_tx, n_empty, n_pend, go_b, go_d, dec, sb, ld;
    @(negedge clk);
    b_tick = (tcnt == 0);
    tcnt = (tcnt + 1) % 3;
    go_b = b_en && (m_pend || b_brk);
    go_d = b_en && !m_empty && !go_b;
    n_st = m_st; n_idx = m_idx; n_last = m_last; n_sh = m_sh; n_tx = m_tx;
    dec = 0; sb = 0; ld = 0;
    if (b_tick) begin
      case (m_st)
        0: dec = 1;
        1: if (m_idx == m_last) dec = 1;
           else begin n_idx = m_idx + 1; n_tx = m_sh[0]; n_sh = {1'b1, m_sh[9:1]}; end
        default: if (m_idx != m_last) n_idx = m_idx + 1;
                 else if (go_b) sb = 1;
                 else begin n_st = 0; n_tx = 1; end
      endcase
      if (dec) begin
        if (go_b) sb = 1;
        else if (go_d) ld = 1;
        else begin n_st = 0; n_tx = 1; end
      end
      if (sb) begin n_st = 2; n_idx = 0; n_tx = 0; n_last = b_nine ? 10 : 9; end
      if (ld) begin
        n_st = 1; n_idx = 0; n_tx = 0; n_last = b_nine ? 10 : 9;
        n_sh = b_nine ? {1'b1, m_hold} : {2'b11, m_hold[7:0]};
      end
    end
    n_pend = (sb || m_st == 2) ? 1'b0 : (m_pend | b_brk);
    n_empty = b_wr ? 1'b0 : (ld ? 1'b1 : m_empty);
    if (b_wr) m_hold = b_wd;
    @(posedge clk); #1;
    m_st = n_st; m_idx = n_idx; m_last = n_last; m_sh = n_sh; m_tx = n_tx;
    m_pend = n_pend; m_empty = n_empty;
    chk(tx === m_tx, (m_st == 2) ? "R5" : "R2", "tx_o vs model", int'(tx), int'(m_tx));
    chk(empty === m_empty, "R3", "empty_o vs model", int'(empty), int'(m_empty));
    if (b_tick && nlog < 4096) begin bitlog[nlog] = tx; nlog++; end
  endtask

  task automatic ticks(input int n);
    int start = nlog;
    while (nlog - start < n) cyc();
  endtask

  task automatic write(input logic [8:0] d);
    b_wr = 1; b_wd = d; cyc(); b_wr = 0;
  endtask

  task automatic pulse_brk();
    b_brk = 1; cyc(); cyc(); b_brk = 0;
  endtask

  function automatic int find0(input int from);
    for (int i = from; i < nlog; i++) if (bitlog[i] == 1'b0) return i;
    return -1;
  endfunction

  function automatic int zrun(input int p);
    int n = 0;
    while (p + n < nlog && bitlog[p + n] == 1'b0) n++;
    return n;
  endfunction

  function automatic int decode(input int p, input int nb);
    int v = 0;
    for (int k = 0; k < nb; k++) if (bitlog[p + 1 + k]) v |= (1 << k);
    return v;
  endfunction

  task automatic frame_chk(input int p, input int nb, input int exp, input string req);
    chk(p >= 0, req, "start bit found", p, 0);
    if (p >= 0) begin
      chk(decode(p, nb) == exp, req, "frame data", decode(p, nb), exp);
      chk(bitlog[p + 1 + nb] == 1'b1, req, "stop bit", int'(bitlog[p + 1 + nb]), 1);
    end
  endtask

  task automatic settle();
    b_brk = 0; b_en = 1; ticks(14); nlog = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p, p2, r;
    repeat (3) @(posedge clk);
    #1;
    chk(tx === 1'b1, "R1", "tx_o in reset", int'(tx), 1);
    chk(empty === 1'b1, "R1", "empty_o in reset", int'(empty), 1);
    @(negedge clk); rst_n = 1;
    cyc();
    chk(tx === 1'b1 && empty === 1'b1, "R1", "after reset release", int'(tx), 1);

    // R2 / R3: 8-bit frame
    settle(); b_nine = 0;
    write(9'h0A5);
    chk(empty === 1'b0, "R3", "empty clear after write", int'(empty), 0);
    ticks(14);
    chk(empty === 1'b1, "R3", "empty set after load", int'(empty), 1);
    frame_chk(find0(0), 8, 'hA5, "R2");

    // R2: 9-bit frame
    settle(); b_nine = 1;
    write(9'h1C3); ticks(15);
    frame_chk(find0(0), 9, 'h1C3, "R2");

    // R4: back-to-back
    settle(); b_nine = 0;
    write(9'h012); ticks(2); write(9'h0E7); ticks(25);
    p = find0(0);
    frame_chk(p, 8, 'h12, "R4");
    frame_chk(p + 10, 8, 'hE7, "R4");

    // R5 / R6 / R8: pulsed break, both lengths
    for (int w = 0; w < 2; w++) begin
      settle(); b_nine = w[0];
      pulse_brk(); ticks(30);
      p = find0(0); r = zrun(p);
      chk(r == 10 + w, "R5", "break block length", r, 10 + w);
      chk(bitlog[p + r] == 1'b1, "R8", "mark after break", int'(bitlog[p + r]), 1);
      chk(find0(p + r) == -1, "R6", "single block from pulse", find0(p + r), -1);
    end

    // R7: held break gives whole blocks
    settle(); b_nine = 0;
    b_brk = 1; ticks(25); b_brk = 0; ticks(30);
    p = find0(0); r = zrun(p);
    chk(r == 30, "R7", "held break zero run", r, 30);
    chk(bitlog[p + r] == 1'b1, "R8", "mark after held break", int'(bitlog[p + r]), 1);

    // R9: break requested mid-frame, plus held word
    settle(); b_nine = 0;
    write(9'h03C); ticks(3); pulse_brk(); write(9'h081); ticks(45);
    p = find0(0);
    frame_chk(p, 8, 'h3C, "R9");
    chk(zrun(p + 10) == 10, "R9", "break right after stop", zrun(p + 10), 10);
    chk(bitlog[p + 20] == 1'b1, "R8", "mark before data", int'(bitlog[p + 20]), 1);
    p2 = find0(p + 20);
    chk(p2 == p + 21, "R9", "held word after break", p2, p + 21);
    frame_chk(p2, 8, 'h81, "R9");

    // R10: disable mid-frame
    settle(); b_nine = 0;
    write(9'h055); ticks(3); b_en = 0; ticks(15);
    p = find0(0);
    frame_chk(p, 8, 'h55, "R10");
    chk(find0(p + 10) == -1, "R10", "idle after disable", find0(p + 10), -1);
    r = nlog;
    write(9'h00F); ticks(20);
    chk(find0(r) == -1, "R10", "no start while disabled", find0(r), -1);
    chk(empty === 1'b0, "R10", "word stays held", int'(empty), 0);
    r = nlog; b_en = 1; ticks(14);
    frame_chk(find0(r), 8, 'h0F, "R10");

    // R11: mode change mid-frame
    settle(); b_nine = 1;
    write(9'h1AA); ticks(3); b_nine = 0; write(9'h033); ticks(30);
    p = find0(0);
    frame_chk(p, 9, 'h1AA, "R11");
    chk(find0(p + 1 + zrun(p + 1) > 0 ? p + 11 : p + 11) == p + 11, "R11", "next start after 11 bits", find0(p + 11), p + 11);
    frame_chk(p + 11, 8, 'h33, "R11");

    // random traffic against the model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 29) == 0) begin b_wr = 1; b_wd = 9'($urandom); end
      if ($urandom_range(0, 149) == 0) b_brk = ~b_brk;
      if ($urandom_range(0, 199) == 0) b_en = ~b_en;
      if ($urandom_range(0, 299) == 0) b_nine = ~b_nine;
      if (nlog >= 4000) nlog = 0;
      cyc();
      b_wr = 0;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule